// File: doc/BRIEF.md
# Clause-22 PHY Register Emulation Bridge

This block lets a standard MII management master talk to two embedded PHY ports that have no real Clause-22 register set. A request names a PHY port, a 5-bit register number and, for writes, 16 bits of data. The bridge builds the 16-bit management register from single bits held in 8-bit per-port bytes, and it splits writes back into those bytes. It answers with a one-cycle done strobe and, for reads, the 16-bit value.

On the back side a sequencer drives an 8-bit byte bus into a local register file. That file holds two writable control bytes per port, and it reflects a status byte per port that comes in on an input. A byte whose merged value would not change is never written. The bus is also brought out as an observation tap. Line-side behaviour and real auto-negotiation are not part of this block. The status bytes arrive from outside.

Top module: `mii_reg_bridge`

## Requirements
- R1: Each byte for port p sits at address 0x10*(p+1) + offset. Offset 0x0C is control byte A, offset 0x0D is control byte B and offset 0x0E is the status byte. The status byte is read-only. Every management access first touches byte A, except that a read of the status or partner register first touches the status byte.
- R2: A read of register 0 (basic control) returns a value built from bytes A and B. It has bit 13 = A[6] (force 100M), bit 12 = A[7] (auto-negotiation enable), bit 11 = B[3] (power down), bit 9 = B[5] (restart) and bit 8 = A[5] (force full duplex). All other bits are 0.
- R3: A write to register 0 reads byte A and then byte B. It then sets A[7:5] from data bits 12, 13 and 8, and B[5] and B[3] from data bits 9 and 11. Other bits keep their values. A byte is written back only if its value changed, with byte A first.
- R4: A read of register 1 (basic status) returns 0x7808, with bit 5 set from status[6] (negotiation complete) and bit 2 set from status[5] (link good).
- R5: Registers 2 and 3 read as 0x0022 and 0x1430, with no bus access.
- R6: A read of register 4 (advertisement) returns 0x0001, with bit 8 = A[3], bit 7 = A[2], bit 6 = A[1] and bit 5 = A[0]. A write sets A[3:0] from data bits 8, 7, 6 and 5. It writes byte A only if the byte changed.
- R7: A read of register 5 (link partner) returns 0x0001, with bit 8 = status[3], bit 7 = status[2], bit 6 = status[1] and bit 5 = status[0]. Bit 14 is also set when any of status[3:0] is set.
- R8: A request to port 2 or higher reads as 0xFFFF and is ignored on write. It finishes the cycle after acceptance with no bus access.
- R9: A read of any register other than 0 to 5 returns 0. A write to any register other than 0 and 4 has no effect and causes no bus write.
- R10: req_ready is high only when the bridge is idle. rsp_done is a one-cycle pulse, and the bridge is idle again in the cycle after it. No bus access happens while the bridge is idle.
- R11: After reset, byte A of each port is 0x8F and byte B is 0x00. Basic control therefore reads 0x1000 and advertisement reads 0x01E1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Bridge idle and able to accept a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_port | input | 5 | PHY port index |
| req_reg | input | 5 | Management register number |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 16 | Read result, valid with rsp_done |
| link_status | input | 16 | Status byte per port, port p in bits [8p+7:8p] |
| bus_valid | output | 1 | Byte bus access this cycle |
| bus_write | output | 1 | Byte bus access is a write |
| bus_addr | output | 8 | Byte bus address |
| bus_wdata | output | 8 | Byte bus write data |
| bus_rdata | output | 8 | Byte bus read data from the register file |

## Verification
On every cycle the assertions check the following:
- A byte write never carries the value already stored at its address.
- The status byte is never written.
- rsp_done is a single-cycle pulse that is followed by an idle cycle.
- An out-of-range port or an identifier read completes at once with no bus traffic.

Only the bench scenarios can show that the bit mapping is correct in each direction. They also show that read-modify-writes leave the untouched bits alone, that repeating a write issues no bus write, and that the two ports are independent. The scoreboard checks these through read-back values, the count of bus writes and the first bus address of each access.

// File: rtl/mii_bridge_pkg.sv
package mii_bridge_pkg;

    localparam int unsigned MII_W   = 16;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned PORT_W  = 5;
    localparam int unsigned REG_W   = 5;

    localparam logic [3:0] OFF_CTRL_A = 4'hC;
    localparam logic [3:0] OFF_CTRL_B = 4'hD;
    localparam logic [3:0] OFF_STAT   = 4'hE;

    localparam logic [BYTE_W-1:0] CTRL_A_RESET = 8'h8F;
    localparam logic [BYTE_W-1:0] CTRL_B_RESET = 8'h00;

    localparam logic [MII_W-1:0] ID_WORD_HI = 16'h0022;
    localparam logic [MII_W-1:0] ID_WORD_LO = 16'h1430;
    localparam logic [MII_W-1:0] NO_PHY_VAL = 16'hFFFF;

    localparam logic [REG_W-1:0] MREG_CTRL = 5'd0;
    localparam logic [REG_W-1:0] MREG_STAT = 5'd1;
    localparam logic [REG_W-1:0] MREG_ID1  = 5'd2;
    localparam logic [REG_W-1:0] MREG_ID2  = 5'd3;
    localparam logic [REG_W-1:0] MREG_ADV  = 5'd4;
    localparam logic [REG_W-1:0] MREG_LPA  = 5'd5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_A,
        ST_FETCH_B,
        ST_STORE_A,
        ST_STORE_B,
        ST_FINISH
    } seq_state_e;

    typedef struct packed {
        logic              write;
        logic [PORT_W-1:0] port;
        logic [REG_W-1:0]  regnum;
        logic [MII_W-1:0]  wdata;
    } mii_req_t;

    function automatic logic [BYTE_W-1:0] port_byte_addr(
        input logic [PORT_W-1:0] port, input logic [3:0] off);
        logic [BYTE_W-1:0] base;
        base = {3'b000, port} + 8'd1;
        return (base << 4) | {4'h0, off};
    endfunction

    function automatic logic reads_status(input logic [REG_W-1:0] r);
        return (r == MREG_STAT) || (r == MREG_LPA);
    endfunction

    function automatic logic needs_fetch(input logic [REG_W-1:0] r,
                                         input logic wr);
        if (r == MREG_CTRL || r == MREG_ADV) return 1'b1;
        if (reads_status(r)) return !wr;
        return 1'b0;
    endfunction

    function automatic logic [MII_W-1:0] build_ctrl(
        input logic [BYTE_W-1:0] a, input logic [BYTE_W-1:0] b);
        logic [MII_W-1:0] v;
        v = '0;
        v[13] = a[6];
        v[12] = a[7];
        v[11] = b[3];
        v[9]  = b[5];
        v[8]  = a[5];
        return v;
    endfunction

    function automatic logic [MII_W-1:0] build_stat(input logic [BYTE_W-1:0] s);
        logic [MII_W-1:0] v;
        v = 16'h7808;
        v[5] = s[6];
        v[2] = s[5];
        return v;
    endfunction

    function automatic logic [MII_W-1:0] build_abil(input logic [3:0] f);
        logic [MII_W-1:0] v;
        v = 16'h0001;
        v[8] = f[3];
        v[7] = f[2];
        v[6] = f[1];
        v[5] = f[0];
        return v;
    endfunction

    function automatic logic [MII_W-1:0] build_lpa(input logic [BYTE_W-1:0] s);
        logic [MII_W-1:0] v;
        v = build_abil(s[3:0]);
        v[14] = |s[3:0];
        return v;
    endfunction

    function automatic logic [BYTE_W-1:0] merge_ctrl_a(
        input logic [BYTE_W-1:0] a, input logic [MII_W-1:0] d);
        return {d[12], d[13], d[8], a[4:0]};
    endfunction

    function automatic logic [BYTE_W-1:0] merge_ctrl_b(
        input logic [BYTE_W-1:0] b, input logic [MII_W-1:0] d);
        return {b[7:6], d[9], b[4], d[11], b[2:0]};
    endfunction

    function automatic logic [BYTE_W-1:0] merge_adv(
        input logic [BYTE_W-1:0] a, input logic [MII_W-1:0] d);
        return {a[7:4], d[8], d[7], d[6], d[5]};
    endfunction

endpackage

// File: rtl/mii_port_regfile.sv
module mii_port_regfile
    import mii_bridge_pkg::*;
#(
    parameter int unsigned NPHY = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [BYTE_W-1:0]      bus_addr,
    input  logic [BYTE_W-1:0]      bus_wdata,
    output logic [BYTE_W-1:0]      bus_rdata,
    input  logic [NPHY*BYTE_W-1:0] link_status
);

    logic [BYTE_W-1:0] ctrl_a_q [NPHY];
    logic [BYTE_W-1:0] ctrl_b_q [NPHY];
    logic [NPHY-1:0]   hit;

    for (genvar p = 0; p < NPHY; p++) begin : g_port
        assign hit[p] = (bus_addr[7:4] == 4'(p + 1));

        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_a_q[p] <= CTRL_A_RESET;
                ctrl_b_q[p] <= CTRL_B_RESET;
            end else if (bus_valid && bus_write && hit[p]) begin
                if (bus_addr[3:0] == OFF_CTRL_A) ctrl_a_q[p] <= bus_wdata;
                if (bus_addr[3:0] == OFF_CTRL_B) ctrl_b_q[p] <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NPHY; p++) begin
            if (hit[p]) begin
                case (bus_addr[3:0])
                    OFF_CTRL_A: bus_rdata = ctrl_a_q[p];
                    OFF_CTRL_B: bus_rdata = ctrl_b_q[p];
                    OFF_STAT:   bus_rdata = link_status[p*BYTE_W +: BYTE_W];
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end

    // R3: a byte is only written when its value actually changes
    p_write_on_change_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write) |-> (bus_wdata != bus_rdata));

    // R1: status byte is read-only and never targeted by a write
    p_status_ro_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write) |-> (bus_addr[3:0] != OFF_STAT));

endmodule

// File: rtl/mii_access_seq.sv
module mii_access_seq
    import mii_bridge_pkg::*;
#(
    parameter int unsigned NPHY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [PORT_W-1:0] req_port,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [MII_W-1:0]  req_wdata,
    output logic              rsp_done,
    output logic [MII_W-1:0]  rsp_rdata,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [BYTE_W-1:0] bus_addr,
    output logic [BYTE_W-1:0] bus_wdata,
    input  logic [BYTE_W-1:0] bus_rdata
);

    localparam logic [PORT_W-1:0] NPHY_L = PORT_W'(NPHY);

    seq_state_e        st_q, st_d;
    mii_req_t          rq_q;
    logic [BYTE_W-1:0] cap_a_q, cap_b_q;
    logic [BYTE_W-1:0] src_a, src_b, new_a, new_b;
    logic              chg_a, chg_b, is_ctrl, port_bad;
    logic [MII_W-1:0]  result;

    assign is_ctrl  = (rq_q.regnum == MREG_CTRL);
    assign port_bad = (rq_q.port >= NPHY_L);

    always_comb begin
        src_a = (st_q == ST_FETCH_A) ? bus_rdata : cap_a_q;
        src_b = (st_q == ST_FETCH_B) ? bus_rdata : cap_b_q;
        new_a = is_ctrl ? merge_ctrl_a(src_a, rq_q.wdata)
                        : merge_adv(src_a, rq_q.wdata);
        new_b = merge_ctrl_b(src_b, rq_q.wdata);
        chg_a = (new_a != src_a);
        chg_b = (new_b != src_b);
    end

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_port >= NPHY_L || !needs_fetch(req_reg, req_write))
                        st_d = ST_FINISH;
                    else
                        st_d = ST_FETCH_A;
                end
            end
            ST_FETCH_A: begin
                if (is_ctrl)                       st_d = ST_FETCH_B;
                else if (rq_q.write && chg_a)      st_d = ST_STORE_A;
                else                               st_d = ST_FINISH;
            end
            ST_FETCH_B: begin
                if (!rq_q.write)                   st_d = ST_FINISH;
                else if (chg_a)                    st_d = ST_STORE_A;
                else if (chg_b)                    st_d = ST_STORE_B;
                else                               st_d = ST_FINISH;
            end
            ST_STORE_A: st_d = (is_ctrl && chg_b) ? ST_STORE_B : ST_FINISH;
            ST_STORE_B: st_d = ST_FINISH;
            ST_FINISH:  st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            rq_q    <= '0;
            cap_a_q <= '0;
            cap_b_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && req_valid) begin
                rq_q.write  <= req_write;
                rq_q.port   <= req_port;
                rq_q.regnum <= req_reg;
                rq_q.wdata  <= req_wdata;
            end
            if (st_q == ST_FETCH_A) cap_a_q <= bus_rdata;
            if (st_q == ST_FETCH_B) cap_b_q <= bus_rdata;
        end
    end

    always_comb begin
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        case (st_q)
            ST_FETCH_A: begin
                bus_valid = 1'b1;
                bus_addr  = port_byte_addr(rq_q.port,
                                reads_status(rq_q.regnum) ? OFF_STAT : OFF_CTRL_A);
            end
            ST_FETCH_B: begin
                bus_valid = 1'b1;
                bus_addr  = port_byte_addr(rq_q.port, OFF_CTRL_B);
            end
            ST_STORE_A: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = port_byte_addr(rq_q.port, OFF_CTRL_A);
                bus_wdata = new_a;
            end
            ST_STORE_B: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = port_byte_addr(rq_q.port, OFF_CTRL_B);
                bus_wdata = new_b;
            end
            default: ;
        endcase
    end

    always_comb begin
        if (port_bad) begin
            result = NO_PHY_VAL;
        end else begin
            case (rq_q.regnum)
                MREG_CTRL: result = build_ctrl(cap_a_q, cap_b_q);
                MREG_STAT: result = build_stat(cap_a_q);
                MREG_ID1:  result = ID_WORD_HI;
                MREG_ID2:  result = ID_WORD_LO;
                MREG_ADV:  result = build_abil(cap_a_q[3:0]);
                MREG_LPA:  result = build_lpa(cap_a_q);
                default:   result = '0;
            endcase
        end
    end

    assign req_ready = (st_q == ST_IDLE);
    assign rsp_done  = (st_q == ST_FINISH);
    assign rsp_rdata = (rsp_done && !rq_q.write) ? result : '0;

    // R10: done is a single pulse followed by an idle cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> (!rsp_done && req_ready));

    // R10: no byte bus activity while idle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !bus_valid);

    // R8: out-of-range port completes next cycle without bus traffic
    p_bad_port_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_port >= NPHY_L) |=> (rsp_done && !bus_valid));

    // R5: identifier registers complete next cycle without bus traffic
    p_id_direct_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (req_reg == MREG_ID1 || req_reg == MREG_ID2))
        |=> (rsp_done && !bus_valid));

endmodule

// File: rtl/mii_reg_bridge.sv
module mii_reg_bridge
    import mii_bridge_pkg::*;
#(
    parameter int unsigned NPHY = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [PORT_W-1:0]      req_port,
    input  logic [REG_W-1:0]       req_reg,
    input  logic [MII_W-1:0]       req_wdata,
    output logic                   rsp_done,
    output logic [MII_W-1:0]       rsp_rdata,
    input  logic [NPHY*BYTE_W-1:0] link_status,
    output logic                   bus_valid,
    output logic                   bus_write,
    output logic [BYTE_W-1:0]      bus_addr,
    output logic [BYTE_W-1:0]      bus_wdata,
    output logic [BYTE_W-1:0]      bus_rdata
);

    mii_access_seq #(.NPHY(NPHY)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_port  (req_port),
        .req_reg   (req_reg),
        .req_wdata (req_wdata),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    mii_port_regfile #(.NPHY(NPHY)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .link_status (link_status)
    );

endmodule

// File: tb/mii_reg_bridge_test.sv
`timescale 1ns/1ps
module mii_reg_bridge_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [4:0]  req_port = '0, req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] link_status = '0;
    logic        req_ready, rsp_done, bus_valid, bus_write;
    logic [15:0] rsp_rdata;
    logic [7:0]  bus_addr, bus_wdata, bus_rdata;

    always #2.5 clk = ~clk;

    mii_reg_bridge uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_port(req_port), .req_reg(req_reg),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .link_status(link_status), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    typedef struct {
        bit          is_read;
        logic [15:0] rdata;
        int          nwr;
        logic [8:0]  first;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0, errors = 0;
    logic [7:0]  m_a [2];
    logic [7:0]  m_b [2];
    int          seen_wr = 0;
    logic [8:0]  seen_first = 9'h100;
    bit          want_ready = 0;
    bit          finished = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // monitor: pops and compares as results appear
    always @(negedge clk) begin
        if (rst) begin
            seen_wr = 0;
            seen_first = 9'h100;
            want_ready = 0;
        end else begin
            if (want_ready) begin
                check(req_ready == 1'b1, "R10", "ready after done", req_ready, 1);
                check(rsp_done == 1'b0, "R10", "done single pulse", rsp_done, 0);
                want_ready = 0;
            end
            if (bus_valid) begin
                if (seen_first[8]) seen_first = {1'b0, bus_addr};
                if (bus_write) seen_wr++;
            end
            if (rsp_done) begin
                if (sb.size() == 0) begin
                    check(0, "R10", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (e.is_read)
                        check(rsp_rdata === e.rdata, e.tag, "read data", rsp_rdata, e.rdata);
                    check(seen_wr == e.nwr, e.tag, "bus writes", seen_wr, e.nwr);
                    check(seen_first === e.first, e.tag, "first bus address", seen_first, e.first);
                end
                seen_wr = 0;
                seen_first = 9'h100;
                want_ready = 1;
            end
        end
    end

    // driver: computes expected items from the requirements
    task automatic access(input int port, input int rg, input bit wr,
                          input logic [15:0] wd, input string tag);
        exp_t        e;
        bit          ok_port;
        logic [7:0]  s, a, b, na, nb;
        ok_port   = (port < 2);
        e.is_read = !wr;
        e.rdata   = 16'h0000;
        e.nwr     = 0;
        e.first   = 9'h100;
        e.tag     = tag;
        if (ok_port) begin
            a = m_a[port]; b = m_b[port];
            s = link_status[port*8 +: 8];
            if (rg == 0 || rg == 4 || (!wr && (rg == 1 || rg == 5)))
                e.first = {1'b0, 8'((port + 1) * 16 + ((rg == 1 || rg == 5) ? 14 : 12))};
            if (!wr) begin
                case (rg)
                    0: e.rdata = {2'b00, a[6], a[7], b[3], 1'b0, b[5], a[5], 8'h00};
                    1: e.rdata = 16'h7808 | (16'(s[6]) << 5) | (16'(s[5]) << 2);
                    2: e.rdata = 16'h0022;
                    3: e.rdata = 16'h1430;
                    4: e.rdata = 16'h0001 | (16'(a[3]) << 8) | (16'(a[2]) << 7)
                                 | (16'(a[1]) << 6) | (16'(a[0]) << 5);
                    5: e.rdata = 16'h0001 | (16'(s[3]) << 8) | (16'(s[2]) << 7)
                                 | (16'(s[1]) << 6) | (16'(s[0]) << 5)
                                 | ((s[3:0] != 0) ? 16'h4000 : 16'h0);
                    default: e.rdata = 16'h0000;
                endcase
            end else if (rg == 0) begin
                na = {wd[12], wd[13], wd[8], a[4:0]};
                nb = {b[7:6], wd[9], b[4], wd[11], b[2:0]};
                e.nwr = int'(na != a) + int'(nb != b);
                m_a[port] = na; m_b[port] = nb;
            end else if (rg == 4) begin
                na = {a[7:4], wd[8], wd[7], wd[6], wd[5]};
                e.nwr = int'(na != a);
                m_a[port] = na;
            end
        end else if (!wr) begin
            e.rdata = 16'hFFFF;
        end
        sb.push_back(e);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr;
        req_port = 5'(port); req_reg = 5'(rg); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", "run timed out", 0, 1);
        finish_run();
    end

    initial begin
        m_a[0] = 8'h8F; m_a[1] = 8'h8F;
        m_b[0] = 8'h00; m_b[1] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
        check(rsp_done == 1'b0, "R10", "done after reset", rsp_done, 0);
        check(bus_valid == 1'b0, "R10", "bus idle after reset", bus_valid, 0);

        access(0, 0, 0, 16'h0, "R11");             // 0x1000
        access(0, 4, 0, 16'h0, "R11");             // 0x01E1

        link_status = 16'h006A;
        access(0, 1, 0, 16'h0, "R4");
        access(0, 5, 0, 16'h0, "R7");
        link_status = 16'h2040;
        access(0, 1, 0, 16'h0, "R4");
        access(0, 5, 0, 16'h0, "R7");              // no remote bits, no ack
        access(1, 1, 0, 16'h0, "R4");              // link good on port 1 only
        access(1, 5, 0, 16'h0, "R7");

        access(1, 2, 0, 16'h0, "R5");
        access(0, 3, 0, 16'h0, "R5");

        access(0, 0, 1, 16'h2100, "R3");           // byte A only
        access(0, 0, 0, 16'h0, "R2");
        access(0, 0, 1, 16'h2100, "R3");           // unchanged: no writes
        access(0, 0, 1, 16'h0A00, "R3");           // both bytes
        access(0, 0, 0, 16'h0, "R2");
        access(0, 0, 1, 16'h3900, "R3");
        access(0, 0, 0, 16'h0, "R2");

        access(1, 4, 1, 16'h0141, "R6");
        access(1, 4, 0, 16'h0, "R6");
        access(1, 4, 1, 16'h0141, "R6");           // unchanged
        access(1, 0, 0, 16'h0, "R1");              // port 1 untouched by port 0 writes
        access(0, 4, 0, 16'h0, "R1");              // port 0 adv untouched by port 1

        access(2, 0, 0, 16'h0, "R8");
        access(3, 0, 1, 16'h2100, "R8");
        access(31, 4, 0, 16'h0, "R8");

        access(0, 7, 0, 16'h0, "R9");
        access(0, 7, 1, 16'hFFFF, "R9");
        access(0, 1, 1, 16'hFFFF, "R9");
        access(0, 5, 1, 16'hFFFF, "R9");
        access(0, 0, 0, 16'h0, "R9");              // state unchanged after ignored writes
        access(0, 4, 0, 16'h0, "R9");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule